// File: doc/BRIEF.md
# SDRAM Refresh and Self-Refresh Scheduler

This block keeps two SDRAM blocks refreshed. A down-counter measures the programmed refresh interval. When the interval runs out, the block raises a request to the access arbiter. Once the arbiter grants it, the block fires a one-clock refresh strobe to every block whose enable is set. It then holds a busy window for the number of clocks selected by a two-bit timing code, and the arbiter keeps normal traffic off the bus for that long.

A level-sensitive self-refresh control drives the low-power mode. While the control is high, the block issues a one-clock entry command to both SDRAM blocks and then freezes its interval counter. When the control drops, it issues a one-clock exit command, and counting resumes from the value that was frozen. A refresh that falls due while the arbiter is busy is held as a single outstanding request. The counter simply stays at zero until the grant arrives.

Top module: `sdram_refresh_sched`

## Requirements
- R1: In the first cycle after reset is released, every output is 0: no strobe, no entry or exit command, no busy window, no request.
- R2: With the grant held high and no self-refresh, successive refresh strobes are exactly (rfsh_count + 1) × 16 clocks apart. The count is captured when a refresh is issued (and at reset) and sets the length of the interval that follows.
- R3: busy_win is high for a number of clocks set by rfsh_timing, captured at issue: 3 for 2'b00, 6 for 2'b01, 9 for 2'b10 and 2'b11. The window starts in the same cycle as the strobe.
- R4: Bit i of ref_strobe is for block i and fires only if bit i of blk_en was 1 when the refresh was issued. When blk_en is 0 for all blocks, refresh_req stays low and no refresh is issued.
- R5: sr_enter pulses for one clock on the edge where self_req is high, self-refresh is not yet active and no busy window is open. A busy window therefore delays entry until it closes.
- R6: sr_exit pulses for one clock on the edge where self_req is low while self-refresh is active. Self-refresh ends at that edge.
- R7: While self-refresh is active, refresh_req is low, no strobe fires and the interval counter does not advance. After exit, the interval continues from where it was frozen.
- R8: A refresh that has fallen due waits with refresh_req high until refresh_gnt is seen. Only one refresh is held pending, so a grant after a long wait produces exactly one strobe.
- R9: Each strobe lasts one clock, and a refresh is issued only on an edge where refresh_req and refresh_gnt are both high. On an edge where a self-refresh entry and a refresh are both possible, the entry is taken and the refresh stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rfsh_count | input | 9 | Refresh interval count; interval = (count + 1) × 16 clocks |
| rfsh_timing | input | 2 | Busy-window length code |
| self_req | input | 1 | Level control: 1 = hold SDRAMs in self-refresh |
| blk_en | input | 2 | Per-block refresh enable |
| refresh_gnt | input | 1 | Arbiter grant for a pending refresh |
| refresh_req | output | 1 | A refresh is due and waiting for a grant |
| ref_strobe | output | 2 | One-clock refresh command, one bit per block |
| sr_enter | output | 1 | One-clock self-refresh entry command |
| sr_exit | output | 1 | One-clock self-refresh exit command |
| busy_win | output | 1 | Bus is occupied by the current refresh |

## Verification
The bench withholds the grant for several intervals and then releases it. A design that queued every missed interval would emit a burst of strobes where exactly one is expected. The bench raises self-refresh right after a strobe and again while a refresh is pending. Together these catch an entry that cuts into a busy window or that loses to a refresh on the same edge. Long self-refresh stretches show whether the counter really freezes: a free-running counter would issue a refresh sooner than the bench's model after exit. The bench also runs all four timing codes and every enable pattern, including both blocks off, and so exposes any mix-up between the 2'b10 and 2'b11 window lengths or a request raised with nothing to refresh.

// File: rtl/sdram_refresh_sched.sv
module sdram_refresh_sched #(
  parameter int CNT_W      = 9,
  parameter int PRE_W      = 4,
  parameter int NBLK       = 2,
  parameter int BUSY_SHORT = 3,
  parameter int BUSY_MID   = 6,
  parameter int BUSY_LONG  = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] rfsh_count,
  input  logic [1:0]       rfsh_timing,
  input  logic             self_req,
  input  logic [NBLK-1:0]  blk_en,
  input  logic             refresh_gnt,
  output logic             refresh_req,
  output logic [NBLK-1:0]  ref_strobe,
  output logic             sr_enter,
  output logic             sr_exit,
  output logic             busy_win
);

  localparam int IW = CNT_W + PRE_W;
  localparam int BW = $clog2(BUSY_LONG + 1);

  logic [IW-1:0] intv_q;
  logic [BW-1:0] busy_q;
  logic          in_sr_q;
  logic [BW-1:0] dur;

  wire due      = (intv_q == '0);
  wire idle     = (busy_q == '0);
  wire go_enter = self_req & ~in_sr_q & idle;
  wire go_exit  = ~self_req & in_sr_q;

  assign refresh_req = due & (|blk_en) & ~in_sr_q;
  wire   issue       = refresh_req & refresh_gnt & idle & ~go_enter;
  assign busy_win    = ~idle;

  always_comb begin
    case (rfsh_timing)
      2'b00:   dur = BW'(BUSY_SHORT);
      2'b01:   dur = BW'(BUSY_MID);
      default: dur = BW'(BUSY_LONG);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      intv_q     <= {rfsh_count, {PRE_W{1'b1}}};
      busy_q     <= '0;
      in_sr_q    <= 1'b0;
      ref_strobe <= '0;
      sr_enter   <= 1'b0;
      sr_exit    <= 1'b0;
    end else begin
      sr_enter   <= go_enter;
      sr_exit    <= go_exit;
      ref_strobe <= issue ? blk_en : '0;

      if (go_enter)     in_sr_q <= 1'b1;
      else if (go_exit) in_sr_q <= 1'b0;

      if (issue)      busy_q <= dur;
      else if (!idle) busy_q <= busy_q - BW'(1);

      if (issue)                  intv_q <= {rfsh_count, {PRE_W{1'b1}}};
      else if (!in_sr_q && !due)  intv_q <= intv_q - IW'(1);
    end
  end

  assert_strobe_opens_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|ref_strobe) |-> busy_win);

  assert_masked_block_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_strobe & ~$past(blk_en)) == '0);

  assert_enter_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sr_enter |=> !sr_enter);

  assert_exit_after_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sr_exit |-> !$past(self_req));

  assert_quiet_in_self_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_sr_q |-> (!refresh_req && ref_strobe == '0));

  assert_single_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|ref_strobe) |=> (ref_strobe == '0));

  assert_granted_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|ref_strobe) |-> $past(refresh_gnt && refresh_req));

endmodule

// File: tb/sdram_refresh_sched_bench.sv
module sdram_refresh_sched_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [8:0] rfsh_count = '0;
  logic [1:0] rfsh_timing = '0;
  logic       self_req = 1'b0;
  logic [1:0] blk_en = 2'b11;
  logic       refresh_gnt = 1'b1;
  logic       refresh_req, sr_enter, sr_exit, busy_win;
  logic [1:0] ref_strobe;

  sdram_refresh_sched u_sdram_refresh_sched (
    .clk(clk), .rst_n(rst_n), .rfsh_count(rfsh_count), .rfsh_timing(rfsh_timing),
    .self_req(self_req), .blk_en(blk_en), .refresh_gnt(refresh_gnt),
    .refresh_req(refresh_req), .ref_strobe(ref_strobe), .sr_enter(sr_enter),
    .sr_exit(sr_exit), .busy_win(busy_win));

  always #4 clk = ~clk;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit started = 0;
  int m_cnt = 0, m_busy = 0;
  bit m_sr = 0, m_ent = 0, m_ext = 0;
  logic [1:0] m_str = '0;
  int n_str = 0, n_ent = 0, n_ext = 0, last_str = 0, last_int = 0;

  function automatic int win_len(input logic [1:0] code);
    return (code == 2'b00) ? 3 : (code == 2'b01) ? 6 : 9;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // reference model
  always @(posedge clk) begin
    bit enter, leave, fire;
    cyc++;
    started = 1;
    if (!rst_n) begin
      m_cnt = rfsh_count * 16 + 15; m_busy = 0; m_sr = 0;
      m_str = '0; m_ent = 0; m_ext = 0;
    end else begin
      enter = self_req && !m_sr && m_busy == 0;
      leave = !self_req && m_sr;
      fire  = !enter && m_cnt == 0 && blk_en != 0 && !m_sr && m_busy == 0 && refresh_gnt;
      m_ent = enter; m_ext = leave;
      m_str = fire ? blk_en : 2'b00;
      if (fire) m_busy = win_len(rfsh_timing);
      else if (m_busy > 0) m_busy--;
      if (fire) m_cnt = rfsh_count * 16 + 15;
      else if (!m_sr && m_cnt > 0) m_cnt--;
      if (enter) m_sr = 1; else if (leave) m_sr = 0;
    end
  end

  always @(negedge clk) begin
    if (started) begin
      chk(ref_strobe == m_str, "R4 R9 ref_strobe", ref_strobe, m_str);
      chk(busy_win == (m_busy > 0), "R3 busy_win", busy_win, m_busy > 0);
      chk(refresh_req == (m_cnt == 0 && blk_en != 0 && !m_sr), "R2 R8 refresh_req",
          refresh_req, m_cnt == 0 && blk_en != 0 && !m_sr);
      chk(sr_enter == m_ent, "R5 sr_enter", sr_enter, m_ent);
      chk(sr_exit == m_ext, "R6 sr_exit", sr_exit, m_ext);
      if (ref_strobe != 0) begin
        n_str++; last_int = cyc - last_str; last_str = cyc;
      end
      n_ent += int'(sr_enter);
      n_ext += int'(sr_exit);
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ref_strobe == 0 && !sr_enter && !sr_exit && !busy_win && !refresh_req,
        "R1 reset outputs", {ref_strobe, sr_enter, sr_exit, busy_win, refresh_req}, 0);
    step(100);
    chk(last_int == 16, "R2 interval count0", last_int, 16);
    rfsh_count = 9'd2; rfsh_timing = 2'b01; step(200);
    chk(last_int == 48, "R2 interval count2", last_int, 48);
    rfsh_timing = 2'b10; step(100);
    rfsh_timing = 2'b11; step(100);
    rfsh_timing = 2'b00;
    blk_en = 2'b01; step(100);
    blk_en = 2'b10; step(100);
    blk_en = 2'b00; n_str = 0; step(150);
    chk(n_str == 0, "R4 no strobes with all blocks off", n_str, 0);
    blk_en = 2'b11; refresh_gnt = 1'b0; n_str = 0; step(200);
    chk(n_str == 0, "R8 no strobe without grant", n_str, 0);
    refresh_gnt = 1'b1; step(3);
    chk(n_str == 1, "R8 one strobe after long wait", n_str, 1);
    step(20);
    n_ent = 0; n_str = 0; self_req = 1'b1; step(300);
    chk(n_ent == 1, "R5 single entry", n_ent, 1);
    chk(n_str == 0, "R7 no refresh in self-refresh", n_str, 0);
    n_ext = 0; self_req = 1'b0; step(100);
    chk(n_ext == 1, "R6 single exit", n_ext, 1);
    @(negedge clk);
    while (ref_strobe == 0) @(negedge clk);
    step(1); self_req = 1'b1; step(30); self_req = 1'b0; step(50);
    refresh_gnt = 1'b0;
    @(negedge clk);
    while (!refresh_req) @(negedge clk);
    step(1); self_req = 1'b1; refresh_gnt = 1'b1; step(40);
    self_req = 1'b0; n_str = 0; step(5);
    chk(n_str == 1, "R9 pending refresh kept through self-refresh", n_str, 1);
    rfsh_count = 9'd1; step(150);
    chk(last_int == 32, "R2 interval count1", last_int, 32);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(8 * 100000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule